// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block turns a reference clock into a continuous, periodic frame sync waveform. A prescaler divides the reference clock into a timebase tick. Each tick lasts one 30-bit back-channel frame at the selected link rate. A high/low phase counter then counts these ticks to shape the sync output.

The high and low durations are each programmed as a 16-bit value equal to the wanted tick count minus one. A duty-mode control chooses between two behaviours:
- Independent high and low times.
- A symmetric waveform whose both halves follow the high-time value.

A source select can replace the internal prescaler with an externally supplied tick strobe. Once enabled, the waveform repeats until the enable is removed, with no further triggering. A one-clock strobe marks every rising edge so downstream logic can align to the start of a frame.

With the default 25 MHz reference, the prescaler divides by 15 on the fast rate (600 ns tick) and by 300 on the slow rate (12 us tick). For example, a 60 Hz, 10 % duty output on the fast rate uses a high value of 2777 and a low value of 24999, which gives about 27,778 ticks per period. A different reference frequency needs the divider parameters scaled to match.

Top module: `fsync_gen`

## Requirements
- R1: With `src_ext`=0 and `rate_slow`=0, one tick spans 15 clocks. The first rising edge of `fs_out` appears 15 clocks after `en` is first sampled high.
- R2: With `src_ext`=0 and `rate_slow`=1, one tick spans 300 clocks. The first rising edge appears 300 clocks after enable.
- R3: With `duty_sym`=0, `fs_out` stays high for `hi_len`+1 ticks and low for `lo_len`+1 ticks.
- R4: With `duty_sym`=1, both the high and the low phase last `hi_len`+1 ticks, and `lo_len` has no effect.
- R5: While `en` stays 1, the waveform repeats every period with identical phase lengths and needs no further trigger.
- R6: `fs_rise` is high for exactly the first clock of every high phase and is low at all other times.
- R7: One clock after `en` is sampled 0, both `fs_out` and `fs_rise` are 0 and all counters are cleared. A later enable restarts from the full first-tick latency.
- R8: `hi_len` and `lo_len` are sampled only when a phase begins. A change during a phase does not alter that phase, and the change applies to the next phase of that kind.
- R9: With `src_ext`=1, each clock in which `ext_tick` is 1 counts as one tick. `fs_out` does not change while `ext_tick` stays 0.
- R10: During and just after reset, `fs_out` and `fs_rise` are 0.
- R11: A programmed value of 0 gives a phase of exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Generator enable; 0 forces output low and clears counters |
| duty_sym | input | 1 | 1 = symmetric 50/50 from `hi_len`; 0 = independent high/low |
| rate_slow | input | 1 | 0 = fast link rate tick; 1 = slow link rate tick |
| src_ext | input | 1 | 0 = internal prescaler tick; 1 = `ext_tick` strobe |
| ext_tick | input | 1 | External tick strobe, one clock per tick |
| hi_len | input | 16 | High duration in ticks, minus one |
| lo_len | input | 16 | Low duration in ticks, minus one |
| fs_out | output | 1 | Frame sync level |
| fs_rise | output | 1 | One-clock strobe on each rising edge of `fs_out` |

## Verification
Every result comes from a register, so each change in `fs_out` and `fs_rise` becomes visible on the clock edge that consumes a tick. Measured from enable, the first rising edge is due after exactly one divider length of clocks. Each later phase lasts its length plus one, multiplied by the divider, in clocks, and the disable response is due one clock after `en` falls. The bench drives inputs and samples outputs on the falling edge. It counts whole clocks spent at each level and compares them with these products, so every phase boundary is checked to the exact cycle rather than within a window.

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int CNT_W    = 16,
  parameter int FAST_DIV = 15,
  parameter int SLOW_DIV = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             duty_sym,
  input  logic             rate_slow,
  input  logic             src_ext,
  input  logic             ext_tick,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             fs_out,
  output logic             fs_rise
);
  localparam int MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int PW     = $clog2(MAXDIV + 1);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);

  logic [PW-1:0]    pre_cnt;
  logic [CNT_W-1:0] cnt, len;
  logic             running;

  wire pre_last = pre_cnt >= (rate_slow ? SLOW_LAST : FAST_LAST);
  wire tick     = en && (src_ext ? ext_tick : pre_last);
  wire [CNT_W-1:0] lo_next = duty_sym ? hi_len : lo_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  pre_cnt <= '0;
    else if (pre_last)  pre_cnt <= '0;
    else                pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      running <= 1'b0;
      fs_out  <= 1'b0;
      fs_rise <= 1'b0;
      cnt     <= '0;
      len     <= '0;
    end else begin
      fs_rise <= 1'b0;
      if (tick) begin
        if (!running) begin
          running <= 1'b1;
          fs_out  <= 1'b1;
          fs_rise <= 1'b1;
          cnt     <= '0;
          len     <= hi_len;
        end else if (cnt == len) begin
          cnt     <= '0;
          fs_out  <= !fs_out;
          fs_rise <= !fs_out;
          len     <= fs_out ? lo_next : hi_len;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fs_out && !fs_rise));

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |-> (fs_out && !$past(fs_out)));

  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> !fs_rise);

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(fs_out));

  p_cnt_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= len));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !fs_out);
endmodule

// File: tb/tb_fsync_gen.sv
module tb_fsync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, duty_sym = 1'b0, rate_slow = 1'b0, src_ext = 1'b0;
  logic        ext_tick = 1'b0;
  logic [15:0] hi_len = '0, lo_len = '0;
  logic        fs_out, fs_rise;
  logic        ext_run = 1'b0;
  int          ext_ph = 0;
  int          tests = 0, fails = 0;

  always #2 clk = ~clk;

  fsync_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .duty_sym(duty_sym),
    .rate_slow(rate_slow), .src_ext(src_ext), .ext_tick(ext_tick),
    .hi_len(hi_len), .lo_len(lo_len), .fs_out(fs_out), .fs_rise(fs_rise)
  );

  always @(negedge clk) begin
    if (ext_run) begin
      ext_ph   = (ext_ph == 2) ? 0 : ext_ph + 1;
      ext_tick = (ext_ph == 0);
    end else begin
      ext_ph   = 0;
      ext_tick = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (fs_out !== 1'b1 && n < 5000);
  endtask

  task automatic run_period(output int h, output int l, output int bad);
    h = 0; l = 0; bad = (fs_rise === 1'b1) ? 0 : 1;
    while (fs_out === 1'b1 && h < 20000) begin
      h++; @(negedge clk);
      if (fs_out === 1'b1 && fs_rise !== 1'b0) bad++;
    end
    while (fs_out === 1'b0 && l < 20000) begin
      l++; @(negedge clk);
      if (fs_out === 1'b0 && fs_rise !== 1'b0) bad++;
    end
  endtask

  task automatic stop_gen();
    @(negedge clk); en = 1'b0; ext_run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 fs_out in reset", int'(fs_out), 0);
    check("R10 fs_rise in reset", int'(fs_rise), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R10 fs_out after reset", int'(fs_out), 0);
  endtask

  task automatic t_fast_separate();
    int n, h, l, b;
    duty_sym = 0; rate_slow = 0; src_ext = 0; hi_len = 2; lo_len = 4;
    en = 1'b1;
    wait_rise(n);
    check("R1 fast first-rise latency", n, 15);
    run_period(h, l, b);
    check("R3 high length", h, 3 * 15);
    check("R3 low length", l, 5 * 15);
    check("R6 strobe first period", b, 0);
    for (int i = 0; i < 3; i++) begin
      run_period(h, l, b);
      check("R5 repeat high", h, 45);
      check("R5 repeat low", l, 75);
      check("R6 strobe repeat", b, 0);
    end
    stop_gen();
  endtask

  task automatic t_slow();
    int n, h, l, b;
    rate_slow = 1; duty_sym = 0; hi_len = 1; lo_len = 2;
    en = 1'b1;
    wait_rise(n);
    check("R2 slow first-rise latency", n, 300);
    run_period(h, l, b);
    check("R2 slow high", h, 2 * 300);
    check("R2 slow low", l, 3 * 300);
    stop_gen();
    rate_slow = 0;
  endtask

  task automatic t_sym();
    int n, h, l, b;
    duty_sym = 1; hi_len = 3; lo_len = 9;
    en = 1'b1;
    wait_rise(n);
    run_period(h, l, b);
    check("R4 sym high", h, 4 * 15);
    check("R4 sym low ignores lo_len", l, 4 * 15);
    stop_gen();
    duty_sym = 0;
  endtask

  task automatic t_disable();
    int n, h, l, b;
    hi_len = 6; lo_len = 6;
    en = 1'b1;
    wait_rise(n);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R7 fs_out low after disable", int'(fs_out), 0);
    check("R7 fs_rise low after disable", int'(fs_rise), 0);
    repeat (20) @(negedge clk);
    check("R7 stays low while disabled", int'(fs_out), 0);
    en = 1'b1;
    wait_rise(n);
    check("R7 restart latency", n, 15);
    stop_gen();
  endtask

  task automatic t_midphase();
    int n, h, l, b;
    hi_len = 5; lo_len = 2;
    en = 1'b1;
    wait_rise(n);
    hi_len = 1;
    run_period(h, l, b);
    check("R8 in-progress high kept", h, 6 * 15);
    check("R8 low length", l, 3 * 15);
    run_period(h, l, b);
    check("R8 new high applied", h, 2 * 15);
    stop_gen();
  endtask

  task automatic t_zero();
    int n, h, l, b;
    hi_len = 0; lo_len = 0;
    en = 1'b1;
    wait_rise(n);
    run_period(h, l, b);
    check("R11 zero high one tick", h, 15);
    check("R11 zero low one tick", l, 15);
    check("R11 strobe", b, 0);
    stop_gen();
  endtask

  task automatic t_ext();
    int n, h, l, b;
    logic prev;
    src_ext = 1; hi_len = 1; lo_len = 0;
    en = 1'b1; ext_run = 1'b1;
    wait_rise(n);
    run_period(h, l, b);
    check("R9 ext high", h, 2 * 3);
    check("R9 ext low", l, 1 * 3);
    check("R9 ext strobe", b, 0);
    ext_run = 1'b0;
    prev = fs_out;
    n = 0;
    repeat (40) begin @(negedge clk); if (fs_out !== prev) n++; end
    check("R9 no change without ext_tick", n, 0);
    stop_gen();
    src_ext = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fast_separate();
    t_slow();
    t_sym();
    t_disable();
    t_midphase();
    t_zero();
    t_ext();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule